// File: doc/BRIEF.md
# Pipeline Hazard and Branch-Flush Controller

This block is the control unit of an in-order, single-issue, five-stage integer pipeline (Fetch, Decode, Execute, Buffer, Writeback). Each cycle it looks at the source registers read by the instruction in Decode. It compares them with the destinations still pending in Execute and Buffer. It also looks at the multi-cycle busy signals and at the branch outcome resolved in Execute. From these it decides whether the front of the pipe must hold, whether Execute must hold, whether a no-op is pushed into Execute, and whether Fetch and Decode must be discarded.

Results that can be forwarded never stall. A dependency stalls only when the producer's data will not exist in time: a late result in Execute, such as a load, or an instruction waiting in Buffer. During a stall, Execute, Buffer and Writeback keep moving, and the slot that opens is filled by a bubble. A taken branch discards Fetch and Decode, and Fetch redirects on the next cycle. This costs exactly two empty slots in Execute.

The controller is a four-state machine:
- RUN: normal flow.
- DEP: the last cycle stalled on a dependency.
- MULTI: the last cycle held for a multi-cycle instruction.
- REFILL: the first cycle after a flush, when Decode is empty.

Every cycle the next state is chosen by priority:
- any state goes to REFILL on a taken branch;
- otherwise to MULTI while a multiply or load/store-multiple is busy;
- otherwise to DEP on a live dependency;
- otherwise to RUN.

Top module: `hz_ctrl`

## Requirements
- R1: After reset the state is RUN. With idle inputs, all six outputs are 0.
- R2: A stall is raised in the same cycle when all of the following hold: `dec_valid` is 1, an enabled read port names register r, and Execute holds a valid destination r with `ex_late`=1. The stall sets `fetch_stall`, `dec_stall` and `ex_bubble` to 1 and `ex_hold` to 0. With `dec_valid`=0 no dependency stall occurs.
- R3: A match against an Execute destination with `ex_late`=0 causes no stall. A match against a Buffer destination with `buf_wait`=0 also causes no stall. Both results are forwarded.
- R4: An enabled source that matches a valid Buffer destination with `buf_wait`=1 gives the same stall outputs as R2.
- R5: Register 15 never creates a dependency. A destination whose valid bit is 0 never creates one, and neither does a read port whose bit in `dec_rd_en` is 0. Port i uses bits [4i+3:4i] of `dec_srcs`.
- R6: While `mul_busy`=1 and no branch is taken, `fetch_stall`, `dec_stall` and `ex_hold` are 1 and `ex_bubble` is 0.
- R7: While `lsm_busy`=1, with no multiply busy and no branch taken, `fetch_stall`, `dec_stall` and `ex_bubble` are 1 and `ex_hold` is 0.
- R8: When `br_taken`=1, `fetch_flush`, `dec_flush` and `ex_bubble` are 1 and both stall outputs are 0, even if a dependency is present. A flush takes priority over any stall.
- R9: In the cycle after a taken branch (REFILL), Decode is treated as empty. `ex_bubble` is 1 and no dependency stall is raised. This gives two bubble cycles per taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_rd_en | input | 3 | Per read port: port is used |
| dec_srcs | input | 12 | Source register numbers, 4 bits per port |
| ex_dst_valid | input | 1 | Execute instruction writes a register |
| ex_dst | input | 4 | Execute destination register |
| ex_late | input | 1 | Execute result not ready until after Buffer |
| buf_dst_valid | input | 1 | Buffer instruction writes a register |
| buf_dst | input | 4 | Buffer destination register |
| buf_wait | input | 1 | Buffer instruction is stalled, result pending |
| mul_busy | input | 1 | Multiply still iterating in Execute |
| lsm_busy | input | 1 | Load/store-multiple still transferring |
| br_taken | input | 1 | Branch in Execute is taken |
| fetch_stall | output | 1 | Hold Fetch |
| dec_stall | output | 1 | Hold Decode |
| ex_hold | output | 1 | Hold Execute |
| ex_bubble | output | 1 | Load a no-op into Execute |
| fetch_flush | output | 1 | Discard Fetch, redirect next cycle |
| dec_flush | output | 1 | Discard Decode |

## Verification
The hardest case to reach is the REFILL cycle in which a dependency is present at the ports and must be ignored. Reaching it takes a taken branch followed immediately by a cycle that shows a late-result match on an enabled source. The bench drives exactly that pair of cycles. It then repeats the same hazard one cycle later, to confirm that the stall comes back once the machine has returned to RUN. Priority is exercised by driving a branch together with a hazard, and a multiply together with a hazard.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DEP    = 2'd1,
        ST_MULTI  = 2'd2,
        ST_REFILL = 2'd3
    } hz_state_e;
endpackage

// File: rtl/hz_src_match.sv
// Compares one Decode read port against the two pending producers.
module hz_src_match #(
    parameter int REG_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic             rd_en,
    input  logic [REG_W-1:0] src,
    input  logic             ex_dst_valid,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_late,
    input  logic             buf_dst_valid,
    input  logic [REG_W-1:0] buf_dst,
    input  logic             buf_wait,
    output logic             blocked
);
    localparam logic [REG_W-1:0] PC_REG = REG_W'(PC_IDX);

    logic src_live;
    logic ex_hit;
    logic buf_hit;

    always_comb begin
        src_live = rd_en && (src != PC_REG);
        // Only producers whose data cannot be forwarded yet matter.
        ex_hit   = ex_dst_valid  && ex_late  && (ex_dst  == src);
        buf_hit  = buf_dst_valid && buf_wait && (buf_dst == src);
        blocked  = src_live && (ex_hit || buf_hit);
    end
endmodule

// File: rtl/hz_detect.sv
// One comparator per read port, OR-reduced into a single hazard flag.
module hz_detect #(
    parameter int REG_W  = 4,
    parameter int NUM_RD = 3,
    parameter int PC_IDX = 15
) (
    input  logic [NUM_RD-1:0]       rd_en,
    input  logic [NUM_RD*REG_W-1:0] srcs,
    input  logic                    ex_dst_valid,
    input  logic [REG_W-1:0]        ex_dst,
    input  logic                    ex_late,
    input  logic                    buf_dst_valid,
    input  logic [REG_W-1:0]        buf_dst,
    input  logic                    buf_wait,
    output logic                    hit
);
    logic [NUM_RD-1:0] port_blk;

    for (genvar g = 0; g < NUM_RD; g++) begin : g_port
        hz_src_match #(
            .REG_W (REG_W),
            .PC_IDX(PC_IDX)
        ) u_match (
            .rd_en        (rd_en[g]),
            .src          (srcs[g*REG_W +: REG_W]),
            .ex_dst_valid (ex_dst_valid),
            .ex_dst       (ex_dst),
            .ex_late      (ex_late),
            .buf_dst_valid(buf_dst_valid),
            .buf_dst      (buf_dst),
            .buf_wait     (buf_wait),
            .blocked      (port_blk[g])
        );
    end

    assign hit = |port_blk;
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int NUM_RD = 3,
    parameter int PC_IDX = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dec_valid,
    input  logic [NUM_RD-1:0]       dec_rd_en,
    input  logic [NUM_RD*REG_W-1:0] dec_srcs,
    input  logic                    ex_dst_valid,
    input  logic [REG_W-1:0]        ex_dst,
    input  logic                    ex_late,
    input  logic                    buf_dst_valid,
    input  logic [REG_W-1:0]        buf_dst,
    input  logic                    buf_wait,
    input  logic                    mul_busy,
    input  logic                    lsm_busy,
    input  logic                    br_taken,
    output logic                    fetch_stall,
    output logic                    dec_stall,
    output logic                    ex_hold,
    output logic                    ex_bubble,
    output logic                    fetch_flush,
    output logic                    dec_flush
);
    hz_state_e state_q, state_d;
    logic      hz_hit;
    logic      dep_live;

    hz_detect #(
        .REG_W (REG_W),
        .NUM_RD(NUM_RD),
        .PC_IDX(PC_IDX)
    ) u_detect (
        .rd_en        (dec_rd_en),
        .srcs         (dec_srcs),
        .ex_dst_valid (ex_dst_valid),
        .ex_dst       (ex_dst),
        .ex_late      (ex_late),
        .buf_dst_valid(buf_dst_valid),
        .buf_dst      (buf_dst),
        .buf_wait     (buf_wait),
        .hit          (hz_hit)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Dependency is only live when Decode really holds an instruction.
    always_comb begin
        unique case (state_q)
            ST_REFILL:                 dep_live = 1'b0;
            ST_RUN, ST_DEP, ST_MULTI:  dep_live = dec_valid && hz_hit;
            default:                   dep_live = 1'b0;
        endcase
    end

    // Next state, by priority: flush, multi-cycle, dependency.
    always_comb begin
        if (br_taken)                  state_d = ST_REFILL;
        else if (mul_busy || lsm_busy) state_d = ST_MULTI;
        else if (dep_live)             state_d = ST_DEP;
        else                           state_d = ST_RUN;
    end

    // Outputs.
    always_comb begin
        fetch_stall = 1'b0;
        dec_stall   = 1'b0;
        ex_hold     = 1'b0;
        ex_bubble   = 1'b0;
        fetch_flush = 1'b0;
        dec_flush   = 1'b0;
        if (br_taken) begin
            fetch_flush = 1'b1;
            dec_flush   = 1'b1;
            ex_bubble   = 1'b1;
        end else if (mul_busy) begin
            fetch_stall = 1'b1;
            dec_stall   = 1'b1;
            ex_hold     = 1'b1;
        end else if (lsm_busy || dep_live) begin
            fetch_stall = 1'b1;
            dec_stall   = 1'b1;
            ex_bubble   = 1'b1;
        end else if (state_q == ST_REFILL) begin
            ex_bubble   = 1'b1;
        end
    end

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (!dec_stall && !fetch_stall && dec_flush));

    assert_refill_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !mul_busy && !lsm_busy) |=> (ex_bubble || ex_hold));

    assert_refill_nodep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !mul_busy && !lsm_busy) |=> (state_q == ST_REFILL));

    assert_hold_no_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_hold |-> !ex_bubble);

    assert_no_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_dst_valid && !buf_dst_valid) |-> !hz_hit);

    assert_dec_stall_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_stall) |-> fetch_stall);
endmodule

// File: tb/hz_ctrl_tb_top.sv
module hz_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [2:0]  dec_rd_en = '0;
    logic [11:0] dec_srcs = '0;
    logic        ex_dst_valid = 1'b0;
    logic [3:0]  ex_dst = '0;
    logic        ex_late = 1'b0;
    logic        buf_dst_valid = 1'b0;
    logic [3:0]  buf_dst = '0;
    logic        buf_wait = 1'b0;
    logic        mul_busy = 1'b0;
    logic        lsm_busy = 1'b0;
    logic        br_taken = 1'b0;
    logic        fetch_stall, dec_stall, ex_hold, ex_bubble, fetch_flush, dec_flush;

    int n_run = 0;
    int n_fail = 0;
    logic [5:0] exp_q[$];
    string      req_q[$];
    bit         done = 1'b0;

    always #5 clk = ~clk;

    hz_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_rd_en(dec_rd_en),
        .dec_srcs(dec_srcs), .ex_dst_valid(ex_dst_valid), .ex_dst(ex_dst),
        .ex_late(ex_late), .buf_dst_valid(buf_dst_valid), .buf_dst(buf_dst),
        .buf_wait(buf_wait), .mul_busy(mul_busy), .lsm_busy(lsm_busy),
        .br_taken(br_taken), .fetch_stall(fetch_stall), .dec_stall(dec_stall),
        .ex_hold(ex_hold), .ex_bubble(ex_bubble), .fetch_flush(fetch_flush),
        .dec_flush(dec_flush)
    );

    // Output order: {fetch_stall, dec_stall, ex_hold, ex_bubble, fetch_flush, dec_flush}
    localparam logic [5:0] IDLE  = 6'b000000;
    localparam logic [5:0] DEPST = 6'b110100;
    localparam logic [5:0] MULH  = 6'b111000;
    localparam logic [5:0] FLSH  = 6'b000111;
    localparam logic [5:0] BUBL  = 6'b000100;

    // Driver: applies one cycle of stimulus at the falling edge and queues the expectation.
    task automatic drive(input logic dv, input logic [2:0] en,
                         input logic [3:0] s0, input logic [3:0] s1, input logic [3:0] s2,
                         input logic exv, input logic [3:0] exd, input logic exl,
                         input logic bv, input logic [3:0] bd, input logic bw,
                         input logic mb, input logic lb, input logic br,
                         input logic [5:0] exp, input string req);
        @(negedge clk);
        dec_valid = dv; dec_rd_en = en; dec_srcs = {s2, s1, s0};
        ex_dst_valid = exv; ex_dst = exd; ex_late = exl;
        buf_dst_valid = bv; buf_dst = bd; buf_wait = bw;
        mul_busy = mb; lsm_busy = lb; br_taken = br;
        exp_q.push_back(exp);
        req_q.push_back(req);
    endtask

    // Monitor: samples shortly before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (exp_q.size() > 0) begin
                logic [5:0] got;
                logic [5:0] want;
                string      r;
                got  = {fetch_stall, dec_stall, ex_hold, ex_bubble, fetch_flush, dec_flush};
                want = exp_q.pop_front();
                r    = req_q.pop_front();
                n_run++;
                if (got !== want) begin
                    n_fail++;
                    $display("FAIL %s: got %b expected %b", r, got, want);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: idle after reset
        drive(0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, IDLE, "R1");
        // R2: load in Execute feeds port 0
        drive(1, 3'b001, 3, 0, 0, 1, 3, 1, 0, 0, 0, 0, 0, 0, DEPST, "R2");
        // R3: same value now in Buffer, not waiting: forwarded
        drive(1, 3'b001, 3, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, IDLE, "R3");
        // R3: early Execute result on port 1
        drive(1, 3'b010, 0, 5, 0, 1, 5, 0, 0, 0, 0, 0, 0, 0, IDLE, "R3");
        // R4: waiting Buffer producer on port 2
        drive(1, 3'b100, 0, 0, 7, 0, 0, 0, 1, 7, 1, 0, 0, 0, DEPST, "R4");
        // R5: register 15
        drive(1, 3'b001, 15, 0, 0, 1, 15, 1, 1, 15, 1, 0, 0, 0, IDLE, "R5");
        // R5: invalid destination
        drive(1, 3'b001, 4, 0, 0, 0, 4, 1, 0, 4, 1, 0, 0, 0, IDLE, "R5");
        // R5: disabled read port
        drive(1, 3'b110, 6, 0, 0, 1, 6, 1, 0, 0, 0, 0, 0, 0, IDLE, "R5");
        // R2: no instruction in Decode
        drive(0, 3'b001, 6, 0, 0, 1, 6, 1, 0, 0, 0, 0, 0, 0, IDLE, "R2");
        // R6: multiply busy with a hazard present
        drive(1, 3'b001, 2, 0, 0, 1, 2, 1, 0, 0, 0, 1, 0, 0, MULH, "R6");
        drive(1, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, MULH, "R6");
        // R7: load/store-multiple busy
        drive(1, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, DEPST, "R7");
        // R8: taken branch beats a hazard
        drive(1, 3'b001, 9, 0, 0, 1, 9, 1, 0, 0, 0, 0, 0, 1, FLSH, "R8");
        // R9: refill cycle ignores the hazard, inserts bubble
        drive(1, 3'b001, 9, 0, 0, 1, 9, 1, 0, 0, 0, 0, 0, 0, BUBL, "R9");
        // R2: hazard stalls again once back in RUN
        drive(1, 3'b001, 9, 0, 0, 1, 9, 1, 0, 0, 0, 0, 0, 0, DEPST, "R2");
        // R2: match on port 1 with all ports enabled
        drive(1, 3'b111, 1, 8, 2, 1, 8, 1, 0, 0, 0, 0, 0, 0, DEPST, "R2");
        // R1: quiet again
        drive(0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, IDLE, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule